// File: doc/BRIEF.md
# Pulse-Count Burst Sequencer

This block drives a PWM timer so that the timer emits an exact number of output periods and then falls silent. The timer can only repeat a period a bounded number of times per update event (at most `REP_MAX + 1` periods, 256 by default). The requested total is a 32-bit number, so the sequencer splits it into chunks. It keeps three values: the periods still owed, the chunk the timer is running now, and the chunk already staged in the timer's repetition preload for the following update.

A start request carries the total. The sequencer first writes the opening chunk and forces an update, which moves that chunk into the timer's active repetition counter. It then stages the chunk for the remainder and turns the counter and output on. On each update event it either retires the finished chunk and stages a new one, or, when the chunk that just ended was the last, it drops the output enable, stops the timer and pulses `done`. The chunk choice looks one step ahead, so no burst finishes with a sliver of a chunk. A zero total selects free-running output.

Top module: `burst_pulse_sequencer`

## Requirements
- R1: After a synchronous reset every output is low and `rep_preload` is 0.
- R2: For a remaining count R, the chunk is R when R <= REP_MAX, (REP_MAX+1)/2 when REP_MAX < R < floor(3*REP_MAX/2), and REP_MAX otherwise. Whenever `rep_wr` is high, `rep_preload` carries chunk-1, or 0 when the chunk is 0.
- R3: A nonzero start that is accepted gives three steps on consecutive cycles. First, `rep_wr` is high with the first chunk minus 1. Second, `force_upd` is high and `run` is low. Third, `rep_wr` is high with the chunk for (total - first chunk) minus 1, and `run`, `main_oe` and `upd_en` are all high.
- R4: Over a burst, the periods the timer completes across all update events add up to exactly the requested total. The number of update events equals the number of chunks.
- R5: At the update event that ends the last chunk, `main_oe`, `run` and `upd_en` fall, and `done` is high for exactly one cycle. Both happen in the cycle after the event is sampled.
- R6: A start with total 0 writes `rep_preload` = 0. It raises `run` and `main_oe`, keeps `upd_en` low and never pulses `done`. A later start is accepted from this free-running state.
- R7: A nonzero start while `rep_capable` is low is refused. `reject` pulses one cycle later, and no write, forced update or run occurs.
- R8: A start that arrives while a burst is in progress is ignored. The running burst delivers its own total, and only one `done` results.
- R9: An update event outside a burst produces no `done`, no write and no change of `run`.
- R10: For a total above REP_MAX, no chunk is smaller than (REP_MAX-1)/2 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, one cycle |
| start_count | input | CNT_W | Requested period total (0 = free-run) |
| rep_capable | input | 1 | Timer has a repetition counter |
| upd_evt | input | 1 | Timer update event, one cycle |
| rep_preload | output | CHK_W | Value for the timer repetition preload |
| rep_wr | output | 1 | Write strobe for `rep_preload` |
| force_upd | output | 1 | Forced update request to the timer |
| run | output | 1 | Timer counter enable |
| main_oe | output | 1 | Main output enable |
| upd_en | output | 1 | Update events are being handled |
| done | output | 1 | Burst finished, one cycle |
| reject | output | 1 | Start refused, one cycle |

## Verification
The assertions check several properties on every cycle. `done` is a single pulse that always follows a sampled update event and always comes with the output, counter and update handling off. A forced update always follows a preload write while the counter is stopped. Every preload value fits below REP_MAX, and a refusal never writes or forces. The exact arithmetic cannot be checked that way and needs the bench's scenarios. Those scenarios check that the chunks add up to the requested total for every chunking regime, the exact boundary totals, the look-ahead floor on chunk size, and that a start arriving mid-burst is ignored. A behavioural timer in the bench reloads from the staged preload on each update, so these checks rest on the periods actually delivered.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_ARM,
    ST_BURST,
    ST_FREE
  } seq_state_t;
endpackage

// File: rtl/burst_chunk_sel.sv
// Picks the next chunk size from a remaining period count.
module burst_chunk_sel #(
  parameter int CNT_W   = 32,
  parameter int REP_MAX = 255,
  parameter int CHK_W   = 8
) (
  input  logic [CNT_W-1:0] remaining,
  output logic [CHK_W-1:0] chunk
);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(REP_MAX);
  localparam logic [CNT_W-1:0] LIM_C  = CNT_W'((3 * REP_MAX) / 2);
  localparam logic [CHK_W-1:0] HALF_K = CHK_W'((REP_MAX + 1) / 2);
  localparam logic [CHK_W-1:0] MAX_K  = CHK_W'(REP_MAX);

  always_comb begin
    if (remaining <= MAX_C) begin
      chunk = remaining[CHK_W-1:0];
    end else if (remaining < LIM_C) begin
      chunk = HALF_K;   // keeps the tail chunk away from tiny sizes
    end else begin
      chunk = MAX_K;
    end
  end
endmodule

// File: rtl/burst_ledger.sv
// Holds periods still owed, the running chunk and the staged chunk.
module burst_ledger #(
  parameter int CNT_W = 32,
  parameter int CHK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld_init,
  input  logic             ld_arm,
  input  logic             ld_step,
  input  logic [CNT_W-1:0] init_total,
  input  logic [CHK_W-1:0] init_chunk,
  input  logic [CHK_W-1:0] arm_chunk,
  input  logic [CHK_W-1:0] step_chunk,
  output logic [CNT_W-1:0] rem_after_prev,
  output logic [CNT_W-1:0] rem_after_both,
  output logic             last_chunk_hit
);
  logic [CNT_W-1:0] owed;
  logic [CHK_W-1:0] prv_chunk;
  logic [CHK_W-1:0] cur_chunk;
  logic [CNT_W-1:0] prv_ext;
  logic [CNT_W-1:0] cur_ext;

  assign prv_ext = {{(CNT_W-CHK_W){1'b0}}, prv_chunk};
  assign cur_ext = {{(CNT_W-CHK_W){1'b0}}, cur_chunk};

  assign rem_after_prev = owed - prv_ext;
  assign rem_after_both = owed - prv_ext - cur_ext;
  assign last_chunk_hit = (owed <= prv_ext);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      owed      <= '0;
      prv_chunk <= '0;
      cur_chunk <= '0;
    end else if (ld_init) begin
      owed      <= init_total;
      prv_chunk <= init_chunk;
      cur_chunk <= '0;
    end else if (ld_arm) begin
      cur_chunk <= arm_chunk;
    end else if (ld_step) begin
      owed      <= owed - prv_ext;
      prv_chunk <= cur_chunk;
      cur_chunk <= step_chunk;
    end
  end
endmodule

// File: rtl/burst_pulse_sequencer.sv
module burst_pulse_sequencer
  import burst_seq_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int REP_MAX = 255,
  localparam int CHK_W  = $clog2(REP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic             rep_capable,
  input  logic             upd_evt,
  output logic [CHK_W-1:0] rep_preload,
  output logic             rep_wr,
  output logic             force_upd,
  output logic             run,
  output logic             main_oe,
  output logic             upd_en,
  output logic             done,
  output logic             reject
);
  localparam int NUM_SEL = 3;  // start total, arm remainder, step remainder

  seq_state_t state;

  logic [CNT_W-1:0] sel_in  [NUM_SEL];
  logic [CHK_W-1:0] sel_out [NUM_SEL];
  logic [CNT_W-1:0] rem_after_prev;
  logic [CNT_W-1:0] rem_after_both;
  logic             last_hit;

  logic accept, zero_req, ld_init, ld_arm, ld_step, finish, clr;

  function automatic logic [CHK_W-1:0] to_pre(input logic [CHK_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  assign sel_in[0] = start_count;
  assign sel_in[1] = rem_after_prev;
  assign sel_in[2] = rem_after_both;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    burst_chunk_sel #(
      .CNT_W  (CNT_W),
      .REP_MAX(REP_MAX),
      .CHK_W  (CHK_W)
    ) u_sel (
      .remaining(sel_in[g]),
      .chunk    (sel_out[g])
    );
  end

  assign accept   = start && (state == ST_IDLE || state == ST_FREE);
  assign zero_req = (start_count == '0);
  assign ld_init  = accept && !zero_req && rep_capable;
  assign ld_arm   = (state == ST_ARM);
  assign finish   = (state == ST_BURST) && upd_evt && last_hit;
  assign ld_step  = (state == ST_BURST) && upd_evt && !last_hit;
  assign clr      = (accept && zero_req) || finish;

  burst_ledger #(
    .CNT_W(CNT_W),
    .CHK_W(CHK_W)
  ) u_ledger (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .ld_init       (ld_init),
    .ld_arm        (ld_arm),
    .ld_step       (ld_step),
    .init_total    (start_count),
    .init_chunk    (sel_out[0]),
    .arm_chunk     (sel_out[1]),
    .step_chunk    (sel_out[2]),
    .rem_after_prev(rem_after_prev),
    .rem_after_both(rem_after_both),
    .last_chunk_hit(last_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rep_preload <= '0;
      rep_wr      <= 1'b0;
      force_upd   <= 1'b0;
      run         <= 1'b0;
      main_oe     <= 1'b0;
      upd_en      <= 1'b0;
      done        <= 1'b0;
      reject      <= 1'b0;
    end else begin
      rep_wr    <= 1'b0;
      force_upd <= 1'b0;
      done      <= 1'b0;
      reject    <= 1'b0;
      case (state)
        ST_IDLE, ST_FREE: begin
          if (start) begin
            if (zero_req) begin
              state       <= ST_FREE;
              rep_preload <= '0;
              rep_wr      <= 1'b1;
              run         <= 1'b1;
              main_oe     <= 1'b1;
              upd_en      <= 1'b0;
            end else if (!rep_capable) begin
              reject <= 1'b1;
            end else begin
              state       <= ST_PRIME;
              rep_preload <= to_pre(sel_out[0]);
              rep_wr      <= 1'b1;
              run         <= 1'b0;
              main_oe     <= 1'b0;
              upd_en      <= 1'b0;
            end
          end
        end
        ST_PRIME: begin
          force_upd <= 1'b1;
          state     <= ST_ARM;
        end
        ST_ARM: begin
          rep_preload <= to_pre(sel_out[1]);
          rep_wr      <= 1'b1;
          run         <= 1'b1;
          main_oe     <= 1'b1;
          upd_en      <= 1'b1;
          state       <= ST_BURST;
        end
        ST_BURST: begin
          if (upd_evt) begin
            if (last_hit) begin
              main_oe <= 1'b0;
              run     <= 1'b0;
              upd_en  <= 1'b0;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              rep_preload <= to_pre(sel_out[2]);
              rep_wr      <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker #(
  parameter int REP_MAX = 255,
  parameter int CHK_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_evt,
  input logic [CHK_W-1:0] rep_preload,
  input logic             rep_wr,
  input logic             force_upd,
  input logic             run,
  input logic             main_oe,
  input logic             upd_en,
  input logic             done,
  input logic             reject
);
  localparam logic [CHK_W-1:0] PRE_TOP = CHK_W'(REP_MAX - 1);

  p_done_after_update_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(upd_evt));

  p_done_quiets_output_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!main_oe && !run && !upd_en));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_force_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    force_upd |-> ($past(rep_wr) && !run && !main_oe));

  p_preload_bound_r2: assert property (@(posedge clk) disable iff (rst)
    rep_wr |-> (rep_preload <= PRE_TOP));

  p_oe_needs_run_r6: assert property (@(posedge clk) disable iff (rst)
    main_oe |-> run);

  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    reject |-> (!rep_wr && !force_upd && !done));

  p_free_no_done_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !upd_en) |=> !done);
endmodule

bind burst_pulse_sequencer burst_seq_checker #(
  .REP_MAX(REP_MAX),
  .CHK_W  (CHK_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_evt    (upd_evt),
  .rep_preload(rep_preload),
  .rep_wr     (rep_wr),
  .force_upd  (force_upd),
  .run        (run),
  .main_oe    (main_oe),
  .upd_en     (upd_en),
  .done       (done),
  .reject     (reject)
);

// File: tb/tb_burst_pulse_sequencer.sv
module tb_burst_pulse_sequencer;
  localparam int CNT_W   = 32;
  localparam int REP_MAX = 255;
  localparam int CHK_W   = 8;
  localparam int PER     = 4;   // clock cycles per timer period
  localparam int NV      = 10;
  localparam int VEC_N [NV] = '{1, 5, 255, 256, 300, 382, 383, 510, 511, 1000};
  localparam int VEC_U [NV] = '{1, 1, 1,   2,   2,   2,   2,   2,   3,   4};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CNT_W-1:0] start_count = '0;
  logic             rep_capable = 1'b1;
  logic             upd_evt;
  logic             tm_upd = 1'b0;
  logic             tb_upd = 1'b0;
  logic [CHK_W-1:0] rep_preload;
  logic             rep_wr, force_upd, run, main_oe, upd_en, done, reject;

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  int upd_cnt = 0;
  int min_chunk = 1 << 30;
  int tm_pre = 0, tm_act = 0, tm_rc = 0, tm_phase = 0;

  assign upd_evt = tm_upd | tb_upd;

  always #5 clk = ~clk;

  burst_pulse_sequencer #(.CNT_W(CNT_W), .REP_MAX(REP_MAX)) dut (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .rep_capable(rep_capable), .upd_evt(upd_evt), .rep_preload(rep_preload),
    .rep_wr(rep_wr), .force_upd(force_upd), .run(run), .main_oe(main_oe),
    .upd_en(upd_en), .done(done), .reject(reject)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural timer: reloads its repetition count from the staged preload
  initial begin
    forever begin
      @(negedge clk);
      tm_upd = 1'b0;
      if (rep_wr) tm_pre = int'(rep_preload);
      if (force_upd) begin
        tm_act = tm_pre; tm_rc = tm_pre; tm_phase = 0;
      end else if (run) begin
        tm_phase++;
        if (tm_phase == PER) begin
          tm_phase = 0;
          if (tm_rc == 0) begin
            tm_upd = 1'b1;
            delivered += tm_act + 1;
            upd_cnt++;
            if (tm_act + 1 < min_chunk) min_chunk = tm_act + 1;
            tm_act = tm_pre; tm_rc = tm_pre;
          end else begin
            tm_rc--;
          end
        end
      end
    end
  end

  task automatic kick(input int n);
    @(negedge clk);
    start = 1'b1; start_count = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    delivered = 0; upd_cnt = 0; min_chunk = 1 << 30;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_burst(input int n, input int exp_upd);
    bit seen;
    kick(n);
    wait_done(seen);
    chk(seen, "R5 done seen", seen, 1);
    chk(delivered == n, "R4 total periods", delivered, n);
    chk(upd_cnt == exp_upd, "R4 update count", upd_cnt, exp_upd);
    chk(!main_oe && !run && !upd_en, "R5 outputs off at done",
        {main_oe, run, upd_en}, 0);
    if (n > REP_MAX)
      chk(min_chunk >= (REP_MAX - 1) / 2, "R10 smallest chunk", min_chunk, (REP_MAX - 1) / 2);
    @(negedge clk);
    chk(!done, "R5 done one cycle", done, 0);
  endtask

  initial begin
    bit seen;
    int dones;
    repeat (3) @(negedge clk);
    chk({rep_preload, rep_wr, force_upd, run, main_oe, upd_en, done, reject} == '0,
        "R1 reset state", {rep_preload, rep_wr, force_upd, run, main_oe, upd_en, done, reject}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!run && !main_oe && !rep_wr, "R1 idle after reset", {run, main_oe, rep_wr}, 0);

    // Table walk across chunking regimes (R2, R4, R10)
    for (int v = 0; v < NV; v++) run_burst(VEC_N[v], VEC_U[v]);

    // R3 and R2: start sequence for 300 (first chunk 128, remainder 172)
    @(negedge clk);
    start = 1'b1; start_count = 300;
    @(negedge clk);
    start = 1'b0;
    delivered = 0; upd_cnt = 0; min_chunk = 1 << 30;
    chk(rep_wr && rep_preload == 127 && !force_upd, "R3 step1 first chunk-1", rep_preload, 127);
    @(negedge clk);
    chk(force_upd && !rep_wr && !run, "R3 step2 forced update", force_upd, 1);
    @(negedge clk);
    chk(rep_wr && rep_preload == 171, "R2 remainder chunk-1", rep_preload, 171);
    chk(run && main_oe && upd_en, "R3 step3 enables", {run, main_oe, upd_en}, 7);
    wait_done(seen);
    chk(delivered == 300, "R4 total 300", delivered, 300);
    @(negedge clk);

    // R7: refused on a timer without a repetition counter
    rep_capable = 1'b0;
    start = 1'b1; start_count = 10;
    @(negedge clk);
    start = 1'b0;
    chk(reject && !rep_wr && !force_upd && !run, "R7 reject pulse", reject, 1);
    @(negedge clk);
    chk(!run && !main_oe && !force_upd, "R7 nothing started", {run, main_oe, force_upd}, 0);
    rep_capable = 1'b1;

    // R9: update event while idle
    tb_upd = 1'b1;
    @(negedge clk);
    tb_upd = 1'b0;
    chk(!done && !rep_wr && !run, "R9 idle update ignored", {done, rep_wr, run}, 0);

    // R6: free-running mode
    start = 1'b1; start_count = 0;
    @(negedge clk);
    start = 1'b0;
    chk(rep_wr && rep_preload == 0 && run && main_oe && !upd_en, "R6 free-run setup",
        {rep_wr, run, main_oe, upd_en}, 14);
    dones = 0;
    repeat (200) begin @(negedge clk); if (done) dones++; end
    chk(dones == 0 && main_oe, "R6 free-run has no done", dones, 0);
    run_burst(5, 1);   // R6 restart from free-running

    // R8: start during a burst is ignored
    kick(300);
    repeat (50) @(negedge clk);
    start = 1'b1; start_count = 7;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk(delivered == 300, "R8 burst total kept", delivered, 300);
    dones = 0;
    repeat (2000) begin @(negedge clk); if (done) dones++; end
    chk(dones == 0 && !run, "R8 no second burst", dones, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule